// File: doc/BRIEF.md
# Radio transaction end-state controller

This block is the packet-transaction sequencer of a low-power radio baseband. It tracks which mode the radio is in and decides where the radio goes once a packet has been sent or received. The controller can run a transmitter or receiver without acknowledgements. It can also run in transaction mode. There, a receiver answers every good packet with an automatic acknowledge packet, and a transmitter waits a bounded window for an acknowledge and reports an error if none arrives.

The destination after a packet is a programmed end state: sleep, idle, transmit synthesiser, receive synthesiser or receive. A one-shot force request sends the radio straight to that programmed state. The request is held back while a packet is on the air, and its status bit clears itself once the jump is done. The acknowledge wait window is counted in microsecond ticks. It is a multiple of the sync-code duration, and that duration depends on whether the short or the long code is selected.

Top module: `txn_end_ctrl`

## Requirements
- R1: After a synchronous reset, `mode` is sleep (000) and `rx_armed`, `ack_tx_req`, `tx_err` and `force_pend` are all 0.
- R2: A `tx_go` strobe in sleep, idle, either synth mode or unarmed receive moves `mode` to transmit (101) on the next edge and clears `tx_err`.
- R3: With `ack_en` low, `pkt_done` in transmit moves `mode` straight to the end state. The `end_sel` codes are 000 sleep, 001 idle, 010 synth-for-transmit, 011 synth-for-receive and 100 receive, and `mode` uses the same codes.
- R4: While armed, once `sop_seen` has been seen, a `pkt_done` with `rx_valid` and `ack_en` both high moves `mode` to ACK transmit (110) with `ack_tx_req` high. The next `pkt_done` then moves `mode` to the end state. A `pkt_done` with `rx_valid` low moves `mode` to the end state without an ACK.
- R5: A `force_set` strobe raises `force_pend` on the next edge. On the edge after that, `mode` becomes the end state, `rx_armed` clears and `force_pend` clears, unless the radio is busy. Busy means transmit, ACK transmit, or armed after a start of packet. While busy, `force_pend` stays high and the jump waits until the radio is no longer busy.
- R6: With `ack_en` high, `pkt_done` in transmit moves `mode` to ACK wait (111). An `ack_rx` strobe there moves `mode` to the end state and leaves `tx_err` at 0.
- R7: The wait window is N = M × L ticks. M is 4, 8, 12 or 15 for `ack_to_sel` 00, 01, 10 or 11. L is LONG_CODE_US when `long_code` is 1 and SHORT_CODE_US otherwise. On the N-th `us_tick` in ACK wait without `ack_rx`, `tx_err` becomes 1 and `mode` goes to the end state. `tx_err` stays 1 until the next accepted `tx_go`.
- R8: Reserved `end_sel` codes 101, 110 and 111 send the radio to idle (001).
- R9: Reaching receive as the end state leaves `rx_armed` at 0. Only `rx_go` sets `rx_armed`, and `sop_seen`, `pkt_done` and `rx_valid` have no effect while the radio is unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_en | input | 1 | Transaction mode: automatic ACK and ACK wait |
| force_set | input | 1 | One-cycle request to jump to the end state |
| end_sel | input | 3 | Programmed end state |
| ack_to_sel | input | 2 | ACK window multiple select |
| long_code | input | 1 | 1: long sync code, 0: short sync code |
| tx_go | input | 1 | Start-transmit strobe |
| rx_go | input | 1 | Arm-receiver strobe |
| sop_seen | input | 1 | Start of packet detected |
| pkt_done | input | 1 | Packet (data or ACK) finished |
| rx_valid | input | 1 | Received packet was good, qualifies `pkt_done` |
| ack_rx | input | 1 | Correct ACK received |
| us_tick | input | 1 | 1 us tick enable |
| mode | output | 3 | Current radio mode |
| rx_armed | output | 1 | Receiver armed |
| ack_tx_req | output | 1 | Request to transmit an ACK packet |
| tx_err | output | 1 | Transmit error, no ACK received in time |
| force_pend | output | 1 | Force request waiting, clears itself |

## Verification
The bench builds the block with SHORT_CODE_US = 2 and LONG_CODE_US = 4. Every wait window then lasts between 8 and 60 ticks. This lets the bench check the timeout boundary tick by tick for both code lengths and the shortest and longest multiples. It also lets random traffic reach timeouts, late ACKs and force requests that hit a busy radio within a few thousand cycles.

// File: rtl/txn_pkg.sv
// Shared types for the radio transaction controller.
// Assumes the mode codes 0..4 match the end-state select encoding.
package txn_pkg;
    typedef enum logic [2:0] {
        M_SLEEP    = 3'd0,
        M_IDLE     = 3'd1,
        M_SYN_TX   = 3'd2,
        M_SYN_RX   = 3'd3,
        M_RX       = 3'd4,
        M_TX       = 3'd5,
        M_ACK_TX   = 3'd6,
        M_ACK_WAIT = 3'd7
    } mode_t;

    // Map an end-state select to a mode; reserved codes fall back to idle.
    function automatic mode_t decode_end(input logic [2:0] sel);
        if (sel <= 3'd4) return mode_t'(sel);
        return M_IDLE;
    endfunction
endpackage

// File: rtl/txn_ack_timer.sv
// ACK wait window counter.
// Loads multiple x code length (in us ticks) when load is high, counts
// down on us ticks while run is high, and pulses expire on the tick that
// would take it from 1 to 0. Assumes run is low in the load cycle.
module txn_ack_timer #(
    parameter int unsigned SHORT_CODE_US = 32,
    parameter int unsigned LONG_CODE_US  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] mult_sel,
    input  logic       long_code,
    input  logic       run,
    input  logic       tick,
    output logic       expire
);
    localparam int unsigned CNT_W = $clog2(15 * LONG_CODE_US + 1);
    localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT_CODE_US);
    localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_CODE_US);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mult;
    logic [CNT_W-1:0] code_len;
    logic [CNT_W-1:0] window;

    // Pick the window multiple and the code length.
    always_comb begin
        case (mult_sel)
            2'd0:    mult = CNT_W'(4);
            2'd1:    mult = CNT_W'(8);
            2'd2:    mult = CNT_W'(12);
            default: mult = CNT_W'(15);
        endcase
        code_len = long_code ? LONG_L : SHORT_L;
        window   = mult * code_len;
    end

    // Load the window or count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= window;
        else if (run && tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = run && tick && (cnt == CNT_W'(1));

    p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt != '0);
endmodule

// File: rtl/txn_force_latch.sv
// Self-clearing force-end request.
// A set strobe is held as pending; the request fires in the first cycle
// the radio is not busy, and pending clears after it fires.
module txn_force_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic busy,
    output logic pend,
    output logic fire
);
    assign fire = pend && !busy;

    // Hold the request until it has been applied.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (fire)
            pend <= 1'b0;
    end

    p_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !busy && !set) |=> !pend);
    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && busy) |=> pend);
endmodule

// File: rtl/txn_end_ctrl.sv
// Packet-transaction state machine of a radio baseband.
// Tracks the radio mode, inserts the automatic ACK phase, times the ACK
// wait and applies force-end requests. Assumes strobes are one cycle wide
// and us_tick is synchronous to clk.
module txn_end_ctrl
    import txn_pkg::*;
#(
    parameter int unsigned SHORT_CODE_US = 32,
    parameter int unsigned LONG_CODE_US  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_en,
    input  logic       force_set,
    input  logic [2:0] end_sel,
    input  logic [1:0] ack_to_sel,
    input  logic       long_code,
    input  logic       tx_go,
    input  logic       rx_go,
    input  logic       sop_seen,
    input  logic       pkt_done,
    input  logic       rx_valid,
    input  logic       ack_rx,
    input  logic       us_tick,
    output logic [2:0] mode,
    output logic       rx_armed,
    output logic       ack_tx_req,
    output logic       tx_err,
    output logic       force_pend
);
    mode_t st;
    mode_t end_m;
    logic  armed;
    logic  sop_hit;
    logic  err;
    logic  busy;
    logic  fire;
    logic  expire;
    logic  tmr_load;

    assign end_m    = decode_end(end_sel);
    assign busy     = (st == M_TX) || (st == M_ACK_TX) || (armed && sop_hit);
    assign tmr_load = (st == M_TX) && pkt_done && ack_en && !fire;

    txn_force_latch u_force (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (force_set),
        .busy  (busy),
        .pend  (force_pend),
        .fire  (fire)
    );

    txn_ack_timer #(
        .SHORT_CODE_US (SHORT_CODE_US),
        .LONG_CODE_US  (LONG_CODE_US)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .mult_sel  (ack_to_sel),
        .long_code (long_code),
        .run       (st == M_ACK_WAIT),
        .tick      (us_tick),
        .expire    (expire)
    );

    // Mode sequencing: force first, then packet events, then start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= M_SLEEP;
            armed   <= 1'b0;
            sop_hit <= 1'b0;
            err     <= 1'b0;
        end else if (fire) begin
            st      <= end_m;
            armed   <= 1'b0;
            sop_hit <= 1'b0;
        end else begin
            case (st)
                M_TX: begin
                    if (pkt_done)
                        st <= ack_en ? M_ACK_WAIT : end_m;
                end
                M_ACK_TX: begin
                    if (pkt_done)
                        st <= end_m;
                end
                M_ACK_WAIT: begin
                    if (ack_rx) begin
                        st <= end_m;
                    end else if (expire) begin
                        st  <= end_m;
                        err <= 1'b1;
                    end
                end
                default: begin
                    if (armed) begin
                        if (sop_seen)
                            sop_hit <= 1'b1;
                        if (pkt_done && sop_hit) begin
                            armed   <= 1'b0;
                            sop_hit <= 1'b0;
                            st      <= (rx_valid && ack_en) ? M_ACK_TX : end_m;
                        end
                    end else if (tx_go) begin
                        st  <= M_TX;
                        err <= 1'b0;
                    end else if (rx_go) begin
                        st    <= M_RX;
                        armed <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign mode       = st;
    assign rx_armed   = armed;
    assign ack_tx_req = (st == M_ACK_TX);
    assign tx_err     = err;

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_TX && !pkt_done) |=> st == M_TX);
    p_ack_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sop_hit && pkt_done && rx_valid && ack_en) |=> st == M_ACK_TX);
    p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(st) == M_ACK_WAIT);
    p_arm_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(rx_go));
endmodule

// File: tb/sim_txn_end_ctrl.sv
`timescale 1ns/1ps
module sim_txn_end_ctrl;
    localparam int SHORT = 2;
    localparam int LONG  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_en = 1'b1, force_set = 1'b0, long_code = 1'b0;
    logic [2:0] end_sel = 3'd0;
    logic [1:0] ack_to_sel = 2'd0;
    logic tx_go = 0, rx_go = 0, sop_seen = 0, pkt_done = 0, rx_valid = 0, ack_rx = 0, us_tick = 0;
    logic [2:0] mode;
    logic rx_armed, ack_tx_req, tx_err, force_pend;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    txn_end_ctrl #(.SHORT_CODE_US(SHORT), .LONG_CODE_US(LONG)) u0 (
        .clk(clk), .rst_n(rst_n), .ack_en(ack_en), .force_set(force_set),
        .end_sel(end_sel), .ack_to_sel(ack_to_sel), .long_code(long_code),
        .tx_go(tx_go), .rx_go(rx_go), .sop_seen(sop_seen), .pkt_done(pkt_done),
        .rx_valid(rx_valid), .ack_rx(ack_rx), .us_tick(us_tick),
        .mode(mode), .rx_armed(rx_armed), .ack_tx_req(ack_tx_req),
        .tx_err(tx_err), .force_pend(force_pend)
    );

    // Expected end mode from the end-state select (R3, R8).
    function automatic logic [2:0] exp_end(input logic [2:0] sel);
        return (sel <= 3'd4) ? sel : 3'd1;
    endfunction

    // Expected wait window in ticks (R7).
    function automatic int exp_window(input logic [1:0] sel, input logic lng);
        int m;
        case (sel)
            2'd0: m = 4;
            2'd1: m = 8;
            2'd2: m = 12;
            default: m = 15;
        endcase
        return m * (lng ? LONG : SHORT);
    endfunction

    // Reference model state, updated at each rising edge from the requirements.
    logic [2:0] m_st;
    logic m_arm, m_sop, m_pend, m_err;
    int   m_cnt;

    always @(posedge clk) begin : model
        logic busy, fire, expd;
        logic [2:0] e;
        if (!rst_n) begin
            m_st = 3'd0; m_arm = 0; m_sop = 0; m_pend = 0; m_err = 0; m_cnt = 0;
        end else begin
            e    = exp_end(end_sel);
            busy = (m_st == 3'd5) || (m_st == 3'd6) || (m_arm && m_sop);
            fire = m_pend && !busy;
            expd = (m_st == 3'd7) && us_tick && (m_cnt == 1);
            if (m_st == 3'd7 && us_tick && m_cnt != 0) m_cnt = m_cnt - 1;
            if (fire) begin
                m_st = e; m_arm = 0; m_sop = 0;
            end else if (m_st == 3'd5) begin
                if (pkt_done) begin
                    if (ack_en) begin m_st = 3'd7; m_cnt = exp_window(ack_to_sel, long_code); end
                    else m_st = e;
                end
            end else if (m_st == 3'd6) begin
                if (pkt_done) m_st = e;
            end else if (m_st == 3'd7) begin
                if (ack_rx) m_st = e;
                else if (expd) begin m_st = e; m_err = 1; end
            end else if (m_arm) begin
                if (pkt_done && m_sop) begin
                    m_arm = 0; m_sop = 0;
                    m_st = (rx_valid && ack_en) ? 3'd6 : e;
                end else if (sop_seen) m_sop = 1;
            end else if (tx_go) begin
                m_st = 3'd5; m_err = 0;
            end else if (rx_go) begin
                m_st = 3'd4; m_arm = 1;
            end
            if (force_set) m_pend = 1;
            else if (fire) m_pend = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output with the model; one check per cycle.
    task automatic chk_model();
        bit ok;
        ok = (mode == m_st) && (rx_armed == m_arm) && (ack_tx_req == (m_st == 3'd6))
             && (tx_err == m_err) && (force_pend == m_pend);
        checks++;
        if (!ok) begin
            fails++;
            if (mode != m_st) $display("FAIL R3 mode actual=%0d expected=%0d", mode, m_st);
            if (rx_armed != m_arm) $display("FAIL R9 rx_armed actual=%0d expected=%0d", rx_armed, m_arm);
            if (ack_tx_req != (m_st == 3'd6)) $display("FAIL R4 ack_tx_req actual=%0d expected=%0d", ack_tx_req, m_st == 3'd6);
            if (tx_err != m_err) $display("FAIL R7 tx_err actual=%0d expected=%0d", tx_err, m_err);
            if (force_pend != m_pend) $display("FAIL R5 force_pend actual=%0d expected=%0d", force_pend, m_pend);
        end
    endtask

    // Advance one clock: inputs set at a falling edge, outputs checked at the next.
    task automatic cyc();
        @(negedge clk);
        if (rst_n) chk_model();
    endtask

    task automatic clr();
        tx_go = 0; rx_go = 0; sop_seen = 0; pkt_done = 0; rx_valid = 0; ack_rx = 0; force_set = 0;
    endtask

    // Run a transmit into ACK wait and let it time out, checking the boundary (R7).
    task automatic run_timeout(input logic [1:0] sel, input logic lng);
        int n;
        n = exp_window(sel, lng);
        ack_to_sel = sel; long_code = lng; ack_en = 1; end_sel = 3'd1; us_tick = 1;
        tx_go = 1; cyc(); clr();
        pkt_done = 1; cyc(); clr();
        chk(mode == 3'd7, "R6 ack wait entry", mode, 7);
        for (int k = 1; k <= n; k++) begin
            cyc();
            if (k == n - 1) chk(mode == 3'd7 && !tx_err, "R7 before window end", {tx_err, mode}, 7);
        end
        chk(tx_err == 1'b1, "R7 error at window end", tx_err, 1);
        chk(mode == 3'd1, "R7 end state after timeout", mode, 1);
        cyc();
        chk(tx_err == 1'b1, "R7 error held", tx_err, 1);
        us_tick = 0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        chk(mode == 3'd0 && !rx_armed && !ack_tx_req && !tx_err && !force_pend,
            "R1 reset state", {mode, rx_armed, ack_tx_req, tx_err, force_pend}, 0);
        rst_n = 1;
        cyc();

        // R5 force from sleep to idle
        end_sel = 3'd1; force_set = 1; cyc(); clr();
        chk(force_pend == 1'b1, "R5 pending after strobe", force_pend, 1);
        cyc();
        chk(mode == 3'd1 && !force_pend, "R5 force applied and cleared", {mode, force_pend}, 2);

        // R2/R3 transmit without ACK
        ack_en = 0; end_sel = 3'd0;
        tx_go = 1; cyc(); clr();
        chk(mode == 3'd5, "R2 transmit entered", mode, 5);
        pkt_done = 1; cyc(); clr();
        chk(mode == 3'd0, "R3 end state without ack", mode, 0);

        // R6 transmit with ACK received
        ack_en = 1; end_sel = 3'd2;
        tx_go = 1; cyc(); clr();
        pkt_done = 1; cyc(); clr();
        chk(mode == 3'd7, "R6 waiting for ack", mode, 7);
        cyc();
        ack_rx = 1; cyc(); clr();
        chk(mode == 3'd2 && !tx_err, "R6 ack received", {tx_err, mode}, 2);

        // R7 window boundaries, short and long codes
        run_timeout(2'd0, 1'b0);
        tx_go = 1; cyc(); clr();
        chk(tx_err == 1'b0, "R2 error cleared by tx_go", tx_err, 0);
        pkt_done = 1; ack_en = 0; cyc(); clr();
        run_timeout(2'd3, 1'b1);
        run_timeout(2'd1, 1'b1);

        // R4 receive with ACK, R9 end in receive unarmed
        ack_en = 1; end_sel = 3'd4;
        rx_go = 1; cyc(); clr();
        chk(mode == 3'd4 && rx_armed, "R9 armed by rx_go", {rx_armed, mode}, 12);
        sop_seen = 1; cyc(); clr();
        pkt_done = 1; rx_valid = 1; cyc(); clr();
        chk(mode == 3'd6 && ack_tx_req, "R4 ack transmit", {ack_tx_req, mode}, 14);
        pkt_done = 1; cyc(); clr();
        chk(mode == 3'd4 && !rx_armed && !ack_tx_req, "R9 receive end state unarmed", {rx_armed, mode}, 4);
        sop_seen = 1; cyc(); clr();
        pkt_done = 1; rx_valid = 1; cyc(); clr();
        chk(mode == 3'd4 && !ack_tx_req && !rx_armed, "R9 packet ignored while unarmed", {ack_tx_req, mode}, 4);

        // R4 bad packet: no ACK
        end_sel = 3'd1;
        rx_go = 1; cyc(); clr();
        sop_seen = 1; cyc(); clr();
        pkt_done = 1; rx_valid = 0; cyc(); clr();
        chk(mode == 3'd1 && !ack_tx_req, "R4 invalid packet no ack", {ack_tx_req, mode}, 1);

        // R5 force held while transmitting
        ack_en = 0; end_sel = 3'd3;
        tx_go = 1; cyc(); clr();
        end_sel = 3'd0; force_set = 1; cyc(); clr();
        cyc(); cyc();
        chk(mode == 3'd5 && force_pend, "R5 force blocked in transmit", {force_pend, mode}, 13);
        pkt_done = 1; cyc(); clr();
        chk(mode == 3'd0 && force_pend, "R5 pending after packet", {force_pend, mode}, 8);
        end_sel = 3'd3; cyc();
        chk(mode == 3'd3 && !force_pend, "R5 deferred force applied", {force_pend, mode}, 3);

        // R8 reserved end code goes to idle
        end_sel = 3'd6; force_set = 1; cyc(); clr(); cyc();
        chk(mode == 3'd1, "R8 reserved code to idle", mode, 1);

        // R5 force while armed before start of packet
        rx_go = 1; cyc(); clr();
        end_sel = 3'd0; force_set = 1; cyc(); clr(); cyc();
        chk(mode == 3'd0 && !rx_armed, "R5 force disarms receiver", {rx_armed, mode}, 0);

        // Random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            tx_go     = ($urandom_range(99) < 6);
            rx_go     = ($urandom_range(99) < 6);
            sop_seen  = ($urandom_range(99) < 12);
            pkt_done  = ($urandom_range(99) < 10);
            rx_valid  = ($urandom_range(99) < 60);
            ack_rx    = ($urandom_range(99) < 3);
            force_set = ($urandom_range(99) < 3);
            us_tick   = ($urandom_range(99) < 70);
            if ($urandom_range(99) < 5) begin
                ack_en     = $urandom_range(1);
                end_sel    = 3'($urandom_range(7));
                ack_to_sel = 2'($urandom_range(3));
                long_code  = $urandom_range(1);
            end
            cyc();
        end
        clr();
        cyc();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule